// File: doc/BRIEF.md
# Block Lock Write-Protect Controller

This block decides, byte by byte, whether a nonvolatile memory controller may commit a write into a 4K-byte array. It holds one protection register. The register is not part of the array address range. It is reached at the top address of the 16-bit request space, FFFFh. The register has three parts: a write-enable latch, a two-bit region-lock code and a hardware-freeze enable bit. The register is modelled as an ordinary flop that loads a reset default.

The serial slave controller presents an address and a write strobe on every byte. It reads the `permit` output in the same clock and drops the byte when `permit` is low. A strobe at FFFFh goes to the protection register. When the `wp_pin` input is high and the freeze bit is set, the region-lock code and the freeze bit itself cannot change. The locked regions of the array then act as read-only memory. With `wp_pin` low, no freeze applies.

Top module: `wp_block_guard`

## Requirements
- R1: After reset, `prot_reg` reads 00h.
- R2: `permit` is 1 for an array write only when the write-enable latch (`prot_reg` bit 1) is 1.
- R3: The region-lock code in `prot_reg` bits 4:3 denies writes in these ranges: 00 denies none, 01 denies C00h to FFFh, 10 denies 800h to FFFh, 11 denies the whole array.
- R4: `permit` is combinational. It can be 1 only while `wr_stb` is 1 and `req_addr` is in the range 0000h to 0FFFh. It is 0 for every other address, FFFFh included.
- R5: A strobe at FFFFh with data bit 1 equal to 0 clears the write-enable latch and leaves every other bit unchanged.
- R6: A strobe at FFFFh with data bit 1 equal to 1 while the latch is 0 sets the latch and changes nothing else.
- R7: A strobe at FFFFh with data bit 1 equal to 1 while the latch is 1 and the register is not frozen loads bit 7 (freeze enable) and bits 4:3 from the data. The latch stays 1.
- R8: While `wp_pin` is 1 and `prot_reg` bit 7 is 1, bits 7 and 4:3 keep their value across any strobe. The latch still follows R5 and R6.
- R9: While `wp_pin` is 0, bit 7 of the register gives no freeze. A new lock code and a cleared freeze bit can both be written.
- R10: Bits 6, 5, 2 and 0 of `prot_reg` always read 0. A strobe at an address from 1000h to FFFEh leaves the register unchanged.
- R11: The register changes only on a strobe at FFFFh. Array writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | 16 | Byte address of the current write request |
| wr_stb | input | 1 | Write request valid this cycle |
| wr_data | input | 8 | Data byte, used when the address is FFFFh |
| wp_pin | input | 1 | Hardware write-protect pin |
| permit | output | 1 | Array write may proceed (combinational) |
| prot_reg | output | 8 | Current protection register value |

## Verification
The checker tests these rules on every cycle:
- the reserved register bits stay zero;
- `permit` never rises without the latch, outside the array, without a strobe, or under a full lock;
- a latch-clearing strobe clears only the latch;
- a frozen register keeps its lock and freeze bits;
- the register never moves without a strobe at FFFFh.

Some behaviour needs scenarios that only the bench drives:
- the exact quarter and half boundaries;
- the two-step enable-then-load sequence;
- a freeze released by lowering the pin;
- strobes at addresses just outside the array.

The bench compares all of these against a model.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    // Bit positions in the visible protection register
    localparam int PR_FRZ_BIT = 7;
    localparam int PR_LK_HI   = 4;
    localparam int PR_LK_LO   = 3;
    localparam int PR_WEL_BIT = 1;

    typedef struct packed {
        logic       frz_en;   // hardware-freeze enable
        logic [1:0] lk_code;  // region-lock code
        logic       wel;      // write-enable latch
    } prot_t;

    function automatic logic [7:0] prot_to_byte(prot_t p);
        logic [7:0] b;
        b = '0;
        b[PR_FRZ_BIT]          = p.frz_en;
        b[PR_LK_HI:PR_LK_LO]   = p.lk_code;
        b[PR_WEL_BIT]          = p.wel;
        return b;
    endfunction

    function automatic prot_t byte_to_prot(logic [7:0] b);
        prot_t p;
        p.frz_en  = b[PR_FRZ_BIT];
        p.lk_code = b[PR_LK_HI:PR_LK_LO];
        p.wel     = b[PR_WEL_BIT];
        return p;
    endfunction

endpackage

// File: rtl/wpc_lock_map.sv
module wpc_lock_map #(
    parameter int REGIONS = 4,
    localparam int RIDX_W = $clog2(REGIONS)
) (
    input  logic [RIDX_W-1:0] region_idx,
    input  logic [1:0]        lk_code,
    output logic              locked
);
    logic [REGIONS-1:0] region_locked;

    // Lock code 01 covers the top region, 10 the upper half, 11 all regions
    for (genvar g = 0; g < REGIONS; g++) begin : g_region
        always_comb begin
            unique case (lk_code)
                2'b00: region_locked[g] = 1'b0;
                2'b01: region_locked[g] = (g >= REGIONS - 1);
                2'b10: region_locked[g] = (g >= REGIONS / 2);
                default: region_locked[g] = 1'b1;
            endcase
        end
    end

    assign locked = region_locked[region_idx];
endmodule

// File: rtl/wpc_reg_next.sv
module wpc_reg_next
    import wpc_pkg::*;
(
    input  prot_t      cur,
    input  logic       do_write,
    input  logic [7:0] data,
    input  logic       frozen,
    output prot_t      nxt
);
    logic unused_data;
    assign unused_data = ^{data[6:5], data[2], data[0]};

    always_comb begin
        nxt = cur;
        if (do_write) begin
            if (!data[PR_WEL_BIT]) begin
                nxt.wel = 1'b0;                 // clear latch only
            end else if (!cur.wel) begin
                nxt.wel = 1'b1;                 // enabling step
            end else if (!frozen) begin
                nxt.frz_en  = data[PR_FRZ_BIT]; // loading step
                nxt.lk_code = data[PR_LK_HI:PR_LK_LO];
            end
        end
    end
endmodule

// File: rtl/wp_block_guard.sv
module wp_block_guard
    import wpc_pkg::*;
#(
    parameter int              AW        = 16,
    parameter int              ARRAY_AW  = 12,
    parameter int              REGIONS   = 4,
    parameter logic [AW-1:0]   REG_ADDR  = 16'hFFFF,
    parameter logic [7:0]      RESET_VAL = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] req_addr,
    input  logic          wr_stb,
    input  logic [7:0]    wr_data,
    input  logic          wp_pin,
    output logic          permit,
    output logic [7:0]    prot_reg
);
    localparam int    RIDX_W     = $clog2(REGIONS);
    localparam prot_t RESET_PROT = byte_to_prot(RESET_VAL);

    typedef struct packed {
        prot_t prot;
    } guard_state_t;

    guard_state_t st_d, st_q;
    prot_t        prot_nxt;
    logic         in_array, reg_hit, frozen, region_lock;

    assign in_array = (req_addr[AW-1:ARRAY_AW] == '0);
    assign reg_hit  = (req_addr == REG_ADDR);
    assign frozen   = wp_pin & st_q.prot.frz_en;

    wpc_lock_map #(.REGIONS(REGIONS)) i_lock_map (
        .region_idx (req_addr[ARRAY_AW-1 -: RIDX_W]),
        .lk_code    (st_q.prot.lk_code),
        .locked     (region_lock)
    );

    wpc_reg_next i_reg_next (
        .cur      (st_q.prot),
        .do_write (wr_stb & reg_hit),
        .data     (wr_data),
        .frozen   (frozen),
        .nxt      (prot_nxt)
    );

    always_comb begin
        st_d.prot = prot_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.prot <= RESET_PROT;
        else        st_q      <= st_d;
    end

    assign permit   = wr_stb & in_array & st_q.prot.wel & ~region_lock;
    assign prot_reg = prot_to_byte(st_q.prot);
endmodule

// File: rtl/wpc_guard_chk.sv
module wpc_guard_chk #(
    parameter int            AW       = 16,
    parameter int            ARRAY_AW = 12,
    parameter logic [AW-1:0] REG_ADDR = 16'hFFFF
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] req_addr,
    input logic          wr_stb,
    input logic [7:0]    wr_data,
    input logic          wp_pin,
    input logic          permit,
    input logic [7:0]    prot_reg
);
    logic unused_chk;
    assign unused_chk = ^{wr_data[7:2], wr_data[0]};

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_reg & 8'b0110_0101) == 8'h00);

    assert_permit_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        permit |-> prot_reg[1]);

    assert_full_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_reg[4:3] == 2'b11) |-> !permit);

    assert_permit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        permit |-> (wr_stb && req_addr[AW-1:ARRAY_AW] == '0));

    assert_wel_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && req_addr == REG_ADDR && !wr_data[1])
        |=> (!prot_reg[1] && $stable({prot_reg[7], prot_reg[4:3]})));

    assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_pin && prot_reg[7]) |=> $stable({prot_reg[7], prot_reg[4:3]}));

    assert_no_stray_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && req_addr == REG_ADDR) |=> $stable(prot_reg));
endmodule

bind wp_block_guard wpc_guard_chk #(
    .AW(AW), .ARRAY_AW(ARRAY_AW), .REG_ADDR(REG_ADDR)
) i_guard_chk (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .wr_stb(wr_stb),
    .wr_data(wr_data), .wp_pin(wp_pin), .permit(permit), .prot_reg(prot_reg)
);

// File: tb/test_wp_block_guard.sv
`timescale 1ns/1ps
module test_wp_block_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_addr = '0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wp_pin = 1'b0;
    logic        permit;
    logic [7:0]  prot_reg;

    int total = 0;
    int bad = 0;
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;

    wp_block_guard i_wp_block_guard (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .wr_stb(wr_stb),
        .wr_data(wr_data), .wp_pin(wp_pin), .permit(permit), .prot_reg(prot_reg)
    );

    function automatic logic exp_permit(logic [7:0] r, logic [15:0] a, logic s);
        logic lk;
        case (r[4:3])
            2'b00: lk = 1'b0;
            2'b01: lk = (a[11:0] >= 12'hC00);
            2'b10: lk = (a[11:0] >= 12'h800);
            default: lk = 1'b1;
        endcase
        return s && (a < 16'h1000) && r[1] && !lk;
    endfunction

    function automatic logic [7:0] exp_next(logic [7:0] r, logic [15:0] a, logic s,
                                            logic [7:0] d, logic wp);
        logic [7:0] n;
        n = r;
        if (s && a == 16'hFFFF) begin
            if (!d[1])       n[1] = 1'b0;
            else if (!r[1])  n[1] = 1'b1;
            else if (!(wp && r[7])) begin
                n[7] = d[7]; n[4:3] = d[4:3];
            end
        end
        return n;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic op(logic [15:0] a, logic s, logic [7:0] d, logic wp, string req);
        logic [7:0] nxt;
        @(negedge clk);
        req_addr = a; wr_stb = s; wr_data = d; wp_pin = wp;
        #2;
        check({req, " permit"}, {7'd0, permit}, {7'd0, exp_permit(model, a, s)});
        nxt = exp_next(model, a, s, d, wp);
        @(posedge clk);
        #2;
        model = nxt;
        check({req, " reg"}, prot_reg, model);
    endtask

    initial begin
        #(20.0 * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] ra;
        logic [7:0]  rd;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2 check("R1 reset", prot_reg, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        op(16'h0000, 1'b1, 8'h00, 1'b0, "R2 no latch");
        op(16'h0100, 1'b0, 8'h00, 1'b0, "R4 no strobe");
        op(16'hFFFF, 1'b1, 8'h9A, 1'b0, "R6 enable only");
        op(16'h0000, 1'b1, 8'h00, 1'b0, "R2 latch set");
        op(16'h1000, 1'b1, 8'h00, 1'b0, "R4 above array");
        op(16'hFFFF, 1'b1, 8'h0A, 1'b0, "R7 load 01");
        op(16'h0BFF, 1'b1, 8'h00, 1'b0, "R3 q below");
        op(16'h0C00, 1'b1, 8'h00, 1'b0, "R3 q edge");
        op(16'hFFFF, 1'b1, 8'h12, 1'b0, "R7 load 10");
        op(16'h07FF, 1'b1, 8'h00, 1'b0, "R3 h below");
        op(16'h0800, 1'b1, 8'h00, 1'b0, "R3 h edge");
        op(16'hFFFF, 1'b1, 8'hFF, 1'b0, "R7 load all R10");
        op(16'h0000, 1'b1, 8'h00, 1'b0, "R3 full");
        op(16'h8000, 1'b1, 8'h00, 1'b0, "R10 stray addr");
        op(16'hFFFE, 1'b1, 8'h02, 1'b0, "R10 FFFE");
        op(16'hFFFF, 1'b1, 8'h02, 1'b1, "R8 frozen load");
        op(16'hFFFF, 1'b1, 8'h00, 1'b1, "R8 R5 clear while frozen");
        op(16'hFFFF, 1'b1, 8'h02, 1'b1, "R8 R6 enable while frozen");
        op(16'hFFFF, 1'b1, 8'h02, 1'b0, "R9 pin low unfreeze");
        op(16'h0FFF, 1'b1, 8'h00, 1'b0, "R11 array write");
        op(16'hFFFF, 1'b1, 8'h19, 1'b0, "R5 clear keeps lock");

        for (int i = 0; i < 600; i++) begin
            case ($urandom_range(0, 3))
                0: ra = 16'hFFFF;
                1: ra = 16'($urandom_range(0, 16'h0FFF));
                2: ra = 16'($urandom_range(16'h1000, 16'hFFFE));
                default: ra = {4'h0, 12'($urandom_range(0, 3) * 12'h400 + 12'h3FF)};
            endcase
            rd = 8'($urandom);
            if ($urandom_range(0, 3) != 0) rd[1] = 1'b1;
            op(ra, 1'($urandom_range(0, 4) != 0), rd, 1'($urandom),
               "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule